// File: doc/BRIEF.md
# Running-Sum Filtered Serial Receiver

This block receives asynchronous serial characters (one start bit, eight data bits sent least significant bit first, one stop bit, no parity) from a line that may carry short glitches. The raw line is brought through a two-flop synchronizer and then sampled on every system clock. A recursive running-sum filter keeps a count of the ones among the most recent M samples. It updates that count each clock by adding the newest sample and removing the one that is M clocks old. A magnitude comparator turns the count into a clean line level.

The window length M is a run-time configuration input. It also sets the bit timing: one bit lasts ten windows, so software programs M to one tenth of the bit period in system clocks. No separate baud-rate timer exists. The framing logic counts windows of M clocks. It samples the clean level at the end of the fifth window of each bit. For every character it gives either a byte with a one-clock valid strobe or a one-clock framing-error pulse.

Top module: `rsu_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_valid and rx_frame_err are 0 and rx_data is 0x00.
- R2: A character whose bits each last 10*M clocks is delivered on rx_data, with bit 0 of the byte taken from the first data bit on the line. rx_data changes only in a cycle where rx_valid is 1.
- R3: Each correctly framed character raises rx_valid for exactly one clock.
- R4: An inverted pulse of at most floor((M-1)/2) clocks, placed inside one bit or on the idle line, changes no received byte and produces no extra event.
- R5: The filtered level is 1 only when the count of ones in the window exceeds M/2 (integer division). For even M, a count of exactly M/2 reads as 0: a 1100 line pattern at M=4 reads as a steady low, and a 1110 pattern reads as high.
- R6: A stop bit sampled as 0 raises rx_frame_err for one clock, produces no rx_valid, and leaves rx_data unchanged.
- R7: After a framing error, no new character starts until the filtered line has been high. A long break then gives only the one error, and the next character after the line returns high is received correctly.
- R8: Bit timing follows the programmed window alone. Characters are received at M = 1, 2, 5 and 8 with bit periods of 10, 20, 50 and 80 clocks.
- R9: A change of cfg_win clears the window count and history and returns the framer to idle. A character in progress is dropped without an event, and the following character at the new M is received.
- R10: A low pulse that the filter passes, but that is high again when the start bit is sampled, is treated as a false start and produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the line is sampled on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win | input | $clog2(MAX_WIN+1) | Window length M in clocks, valid range 1..MAX_WIN (0 acts as 1, larger values as MAX_WIN) |
| rx_line | input | 1 | Raw asynchronous serial line, idle high |
| rx_data | output | DATA_W | Last correctly received byte |
| rx_valid | output | 1 | One-clock strobe marking a new byte on rx_data |
| rx_frame_err | output | 1 | One-clock pulse when a stop bit is sampled low |

## Verification
The filter properties assume that cfg_win stays within 1..MAX_WIN and is held steady for many bit periods between changes. The bench only ever programs values from 1 to 8 and waits at least twenty windows after each change. The pulse and exclusivity properties assume that the line is driven at 10*M clocks per bit and that any glitch is shorter than half a window. The stimulus builds every character from whole bits of exactly that length. The only exceptions are the deliberate tie pattern, the break, the false start and the aborted frame, and none of them breaks a property.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP,
        FR_HOLD
    } fr_state_e;

    // Windows of M clocks that make one bit on the line.
    localparam int unsigned WINDOWS_PER_BIT = 10;
    // Index of the window whose last clock is the mid-bit sample point.
    localparam int unsigned SAMPLE_WIN      = 4;
endpackage

// File: rtl/rsu_sync.sv
module rsu_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= 2'b11;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[1];
endmodule

// File: rtl/rsu_rrs_filter.sv
module rsu_rrs_filter #(
    parameter int unsigned MAX_WIN = 256,
    parameter int unsigned WIN_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIN_W-1:0] m_win,
    input  logic             din,
    output logic [WIN_W-1:0] sum
);
    localparam int unsigned IDX_W = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    typedef struct packed {
        logic [MAX_WIN-1:0] hist;
        logic [WIN_W-1:0]   sum;
    } flt_t;

    flt_t q, d;
    logic [IDX_W-1:0] tap;
    logic             oldest;

    always_comb begin
        tap    = IDX_W'(m_win - ONE);
        oldest = q.hist[tap];
        d      = q;
        if (MAX_WIN > 1) d.hist = {q.hist[MAX_WIN-2:0], din};
        else             d.hist = din;
        d.sum  = q.sum + WIN_W'(din) - WIN_W'(oldest);
        if (clr) begin
            d.hist = '0;
            d.sum  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sum = q.sum;
endmodule

// File: rtl/rsu_compare.sv
module rsu_compare #(
    parameter int unsigned WIN_W = 9
) (
    input  logic [WIN_W-1:0] sum,
    input  logic [WIN_W-1:0] m_win,
    output logic             level
);
    always_comb begin
        level = (sum > (m_win >> 1));
    end
endmodule

// File: rtl/rsu_framer.sv
module rsu_framer
    import rsu_pkg::*;
#(
    parameter int unsigned WIN_W  = 9,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [WIN_W-1:0]  m_win,
    input  logic              line_lvl,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              ferr
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    typedef struct packed {
        fr_state_e         st;
        logic [WIN_W-1:0]  clk_cnt;
        logic [3:0]        win_cnt;
        logic [BIT_W-1:0]  bit_idx;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              ferr;
        logic              prev;
    } fr_t;

    fr_t  q, d;
    logic tick, sample, last_win, counting;

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        d.ferr   = 1'b0;
        d.prev   = line_lvl;
        tick     = (q.clk_cnt == (m_win - ONE));
        sample   = tick && (q.win_cnt == 4'(SAMPLE_WIN));
        last_win = tick && (q.win_cnt == 4'(WINDOWS_PER_BIT - 1));
        counting = (q.st == FR_START) || (q.st == FR_DATA) || (q.st == FR_STOP);

        if (counting) begin
            if (tick) begin
                d.clk_cnt = '0;
                d.win_cnt = last_win ? 4'd0 : q.win_cnt + 4'd1;
            end else begin
                d.clk_cnt = q.clk_cnt + ONE;
            end
        end

        unique case (q.st)
            FR_IDLE: begin
                if (q.prev && !line_lvl) begin
                    d.st      = FR_START;
                    d.clk_cnt = '0;
                    d.win_cnt = '0;
                    d.bit_idx = '0;
                end
            end
            FR_START: begin
                if (sample && line_lvl) d.st = FR_IDLE;
                else if (last_win)      d.st = FR_DATA;
            end
            FR_DATA: begin
                if (sample) d.shreg = {line_lvl, q.shreg[DATA_W-1:1]};
                if (last_win) begin
                    if (q.bit_idx == BIT_W'(DATA_W - 1)) d.st = FR_STOP;
                    else                                 d.bit_idx = q.bit_idx + 1'b1;
                end
            end
            FR_STOP: begin
                if (sample) begin
                    if (line_lvl) begin
                        d.valid = 1'b1;
                        d.data  = q.shreg;
                        d.st    = FR_IDLE;
                    end else begin
                        d.ferr  = 1'b1;
                        d.st    = FR_HOLD;
                    end
                end
            end
            FR_HOLD: begin
                if (line_lvl) d.st = FR_IDLE;
            end
            default: d.st = FR_IDLE;
        endcase

        if (clr) begin
            d.st      = FR_IDLE;
            d.clk_cnt = '0;
            d.win_cnt = '0;
            d.bit_idx = '0;
            d.valid   = 1'b0;
            d.ferr    = 1'b0;
            d.prev    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= FR_IDLE;
        end else begin
            q <= d;
        end
    end

    assign data  = q.data;
    assign valid = q.valid;
    assign ferr  = q.ferr;
endmodule

// File: rtl/rsu_rx.sv
module rsu_rx #(
    parameter  int unsigned MAX_WIN = 256,
    parameter  int unsigned DATA_W  = 8,
    localparam int unsigned WIN_W   = $clog2(MAX_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err
);
    logic [WIN_W-1:0] m_eff, m_d, m_q;
    logic             cfg_clr;
    logic             line_sync;
    logic [WIN_W-1:0] win_sum;
    logic             line_lvl;

    // Clamp the programmed window into 1..MAX_WIN and flag any change.
    always_comb begin
        if (cfg_win == '0)                   m_eff = WIN_W'(1);
        else if (cfg_win > WIN_W'(MAX_WIN))  m_eff = WIN_W'(MAX_WIN);
        else                                 m_eff = cfg_win;
        cfg_clr = (m_eff != m_q);
        m_d     = m_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= WIN_W'(1);
        else        m_q <= m_d;
    end

    rsu_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_sync)
    );

    rsu_rrs_filter #(
        .MAX_WIN(MAX_WIN),
        .WIN_W  (WIN_W)
    ) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cfg_clr),
        .m_win(m_q),
        .din  (line_sync),
        .sum  (win_sum)
    );

    rsu_compare #(
        .WIN_W(WIN_W)
    ) u_cmp (
        .sum  (win_sum),
        .m_win(m_q),
        .level(line_lvl)
    );

    rsu_framer #(
        .WIN_W (WIN_W),
        .DATA_W(DATA_W)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_clr),
        .m_win   (m_q),
        .line_lvl(line_lvl),
        .data    (rx_data),
        .valid   (rx_valid),
        .ferr    (rx_frame_err)
    );
endmodule

// File: rtl/rsu_rx_checker.sv
module rsu_rx_checker #(
    parameter int unsigned WIN_W  = 9,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_frame_err,
    input logic              cfg_clr,
    input logic [WIN_W-1:0]  win_sum,
    input logic [WIN_W-1:0]  win_m,
    input logic              line_lvl
);
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_sum_le_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_sum <= win_m);

    p_tie_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({win_sum, 1'b0} == {1'b0, win_m}) |-> !line_lvl);

    p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sum == win_m) |-> line_lvl);

    p_ferr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err);

    p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_err));

    p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> (!rx_valid && !rx_frame_err && (win_sum == '0)));
endmodule

bind rsu_rx rsu_rx_checker #(
    .WIN_W (WIN_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_frame_err(rx_frame_err),
    .cfg_clr     (cfg_clr),
    .win_sum     (win_sum),
    .win_m       (m_q),
    .line_lvl    (line_lvl)
);

// File: tb/rsu_rx_test.sv
module rsu_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_WIN    = 256;
    localparam int DATA_W     = 8;
    localparam int WIN_W      = $clog2(MAX_WIN + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WIN_W-1:0]  cfg_win = WIN_W'(1);
    logic              rx_line = 1'b1;
    logic [DATA_W-1:0] rx_data;
    logic              rx_valid;
    logic              rx_frame_err;

    int n_cmp = 0, n_bad = 0;
    int n_valid = 0, n_ferr = 0, run = 0, max_run = 0;
    int m_cur = 1;
    logic [DATA_W-1:0] last_data = '0;
    bit done = 0;

    rsu_rx #(.MAX_WIN(MAX_WIN), .DATA_W(DATA_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_win     (cfg_win),
        .rx_line     (rx_line),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_frame_err(rx_frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_valid++;
                last_data = rx_data;
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
            if (rx_frame_err) n_ferr++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rx_line <= lvl;
        repeat (n) @(posedge clk);
    endtask

    task automatic set_win(input int m);
        cfg_win <= WIN_W'(m);
        m_cur = m;
        hold(1'b1, 20 * m + 10);
    endtask

    // One bit of 10*M clocks, optionally with an inverted glitch of g clocks.
    task automatic send_bit(input logic b, input int g);
        if (g > 0) begin
            hold(b, 3 * m_cur);
            hold(~b, g);
            hold(b, 7 * m_cur - g);
        end else begin
            hold(b, 10 * m_cur);
        end
    endtask

    task automatic send_frame(input logic [7:0] v, input logic stop, input int g);
        send_bit(1'b0, g);
        for (int i = 0; i < 8; i++) send_bit(v[i], g);
        send_bit(stop, g);
    endtask

    task automatic expect_rx(input logic [7:0] v, input int g, input string req);
        int v0, f0;
        v0 = n_valid;
        f0 = n_ferr;
        send_frame(v, 1'b1, g);
        hold(1'b1, 20 * m_cur + 10);
        check((n_valid == v0 + 1) && (n_ferr == f0), req, n_valid - v0, 1);
        check(last_data == v, req, int'(last_data), int'(v));
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v0, f0;
        logic [7:0] keep;

        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet while in reset
        check(!rx_valid && !rx_frame_err && rx_data == '0, "R1 in reset",
              int'(rx_valid) + int'(rx_frame_err) + int'(rx_data), 0);
        @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check(!rx_valid && !rx_frame_err && rx_data == '0, "R1 after reset",
              int'(rx_valid) + int'(rx_frame_err) + int'(rx_data), 0);

        // R2 R8: exhaustive byte sweep at M=2 (20 clocks per bit)
        set_win(2);
        for (int b = 0; b < 256; b++) expect_rx(8'(b), 0, "R2 R8 sweep M=2");

        // R8: other window lengths
        set_win(1);
        expect_rx(8'hA5, 0, "R8 M=1");
        expect_rx(8'h5A, 0, "R8 M=1");
        set_win(5);
        expect_rx(8'h01, 0, "R8 M=5");
        expect_rx(8'h80, 0, "R8 M=5");
        set_win(8);
        expect_rx(8'hFF, 0, "R8 M=8");
        expect_rx(8'h00, 0, "R8 M=8");

        // R3: every valid strobe so far lasted one clock
        check(max_run == 1, "R3 valid width", max_run, 1);

        // R4: glitches of floor((7-1)/2)=3 clocks at M=7
        set_win(7);
        v0 = n_valid;
        f0 = n_ferr;
        hold(1'b1, 5 * 7);
        hold(1'b0, 3);
        hold(1'b1, 20 * 7);
        check(n_valid == v0 && n_ferr == f0, "R4 idle glitch", n_valid + n_ferr - v0 - f0, 0);
        expect_rx(8'hC3, 3, "R4 glitched frame");
        expect_rx(8'h3C, 3, "R4 glitched frame");

        // R5: tie at even M reads low, 3 of 4 reads high
        set_win(4);
        v0 = n_valid;
        f0 = n_ferr;
        for (int k = 0; k < 150; k++) begin
            hold(1'b1, 2);
            hold(1'b0, 2);
        end
        hold(1'b1, 100);
        check(n_ferr == f0 + 1 && n_valid == v0, "R5 tie reads low", n_ferr - f0, 1);
        v0 = n_valid;
        f0 = n_ferr;
        for (int k = 0; k < 150; k++) begin
            hold(1'b1, 3);
            hold(1'b0, 1);
        end
        hold(1'b1, 100);
        check(n_ferr == f0 && n_valid == v0, "R5 majority reads high", n_ferr + n_valid - f0 - v0, 0);

        // R6: low stop bit gives a framing error and keeps rx_data
        set_win(3);
        expect_rx(8'h6E, 0, "R6 preload");
        keep = rx_data;
        v0 = n_valid;
        f0 = n_ferr;
        send_frame(8'h11, 1'b0, 0);
        hold(1'b1, 80);
        check(n_ferr == f0 + 1, "R6 error pulse", n_ferr - f0, 1);
        check(n_valid == v0, "R6 no valid", n_valid - v0, 0);
        @(negedge clk);
        check(rx_data == keep, "R6 data kept", int'(rx_data), int'(keep));

        // R7: break after error gives one error, then recovery
        v0 = n_valid;
        f0 = n_ferr;
        send_frame(8'h22, 1'b0, 0);
        hold(1'b0, 400);
        check(n_ferr == f0 + 1 && n_valid == v0, "R7 single error in break", n_ferr - f0, 1);
        hold(1'b1, 70);
        expect_rx(8'h9D, 0, "R7 recovery");

        // R10: filtered low pulse that is high at the start sample
        set_win(6);
        v0 = n_valid;
        f0 = n_ferr;
        hold(1'b0, 18);
        hold(1'b1, 200);
        check(n_valid == v0 && n_ferr == f0, "R10 false start", n_valid + n_ferr - v0 - f0, 0);
        expect_rx(8'h4B, 0, "R10 next frame");

        // R9: change of window mid-frame aborts silently
        set_win(5);
        v0 = n_valid;
        f0 = n_ferr;
        hold(1'b0, 50);
        hold(1'b1, 50);
        hold(1'b0, 50);
        cfg_win <= WIN_W'(4);
        m_cur = 4;
        hold(1'b1, 200);
        check(n_valid == v0 && n_ferr == f0, "R9 aborted frame silent", n_valid + n_ferr - v0 - f0, 0);
        expect_rx(8'h96, 0, "R9 frame at new M");

        check(max_run == 1, "R3 valid width final", max_run, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule